// File: doc/BRIEF.md
# Ghost-Key and Function-Layer Frame Filter

This block sits after the scanner of a key matrix and cleans up one scan frame at a time. A frame opens with a start strobe. The scanner then sends the scancodes of the pressed keys one per cycle and closes the frame with an end strobe. Each scancode packs a row number above a column number. The filter keeps up to `MAX_KEYS` keys and then settles two questions about the frame.

The first question is whether the frame shows the rectangle pattern of a matrix without diodes. When some key shares a row with one pressed key and a column with another, a fourth, phantom key may appear. If the ghost filter is on, the block then flags the whole frame for discard. The second question concerns the function layer. If the layer is on and the function key is down, that key is removed from the list, and every remaining scancode is moved into the upper half of a map that is twice as large.

The result comes back as a list of codes, a count and a discard flag, all marked by a one-cycle done strobe. Consumers translate the codes to keycodes elsewhere.

Top module: `keyscan_filter`

## Requirements
- R1: A frame is opened by `frm_start` while the block is idle and closed by `frm_end`. Key strobes arriving outside an open frame are ignored. `frm_start`, `key_valid` and `frm_end` that arrive while a closed frame is still being processed are ignored. A key strobe in the same cycle as the `frm_start` that opens the frame is ignored.
- R2: At most `MAX_KEYS` (default 8) keys are kept, in arrival order, and later ones are dropped. `out_count` gives the number kept. Slot s of `out_codes` is bits [8s+7:8s]. Slots at or above the count read zero.
- R3: A scancode is 7 bits: the column is bits [2:0] and the row is bits [6:3]. Keys within a frame are distinct codes.
- R4: When the ghost filter is on and at least 3 keys are kept, `discard` is 1 exactly when some kept key shares its row with another kept key and its column with another kept key.
- R5: `discard` is 0 whenever the ghost filter is off or fewer than 3 keys are kept.
- R6: When the function layer is on and the function code (default 60, row 7 column 4) arrives, it is not kept, not counted and not checked for ghosting. Every kept code is reported with bit 7 set, that is, offset by 128. This applies even if the key list is already full.
- R7: When the function layer is off, the function code is an ordinary key. When no function key arrives, no code is offset.
- R8: `done` is high for exactly one cycle per closed frame. `discard`, `out_count` and `out_codes` are valid in that cycle and hold until the next `done`.
- R9: After reset, `done`, `discard`, `out_count` and `out_codes` are all zero.
- R10: `ghost_en` and `fn_layer_en` are sampled when the frame opens. Changes during the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ghost_en | input | 1 | Enable the ghost check, sampled at frame open |
| fn_layer_en | input | 1 | Enable function-layer handling, sampled at frame open |
| frm_start | input | 1 | Opens a frame |
| key_valid | input | 1 | A scancode is present on `key_code` |
| key_code | input | 7 | Pressed-key scancode, row in [6:3] and column in [2:0] |
| frm_end | input | 1 | Closes the open frame |
| done | output | 1 | One-cycle result strobe |
| discard | output | 1 | Frame shows a ghost pattern and should be ignored |
| out_count | output | $clog2(MAX_KEYS+1) | Number of reported codes |
| out_codes | output | 8*MAX_KEYS | Reported codes, slot s at bits [8s+7:8s] |

## Verification
The hardest case to reach from the ports is one where the function key interacts with both capacity and ghosting. In one such case the function key arrives after the list is already full. In the other, the function key is the only link that closes a row/column rectangle: with the layer on the frame must pass, and with it off the same frame must be discarded.

Directed frames build these cases explicitly. They also send strobes while a frame is in progress and flip the enables in the middle of a frame. Random frames then draw codes from a narrow 3×3 corner of the matrix about half the time, so that frames which share a row and a column come up often. The function code is mixed in at random.

// File: rtl/kf_pkg.sv
package kf_pkg;

    localparam int KF_COL_W  = 3;
    localparam int KF_ROW_W  = 4;
    localparam int KF_CODE_W = KF_ROW_W + KF_COL_W;
    localparam int KF_OUT_W  = KF_CODE_W + 1;

    typedef logic [KF_CODE_W-1:0] scan_t;
    typedef logic [KF_OUT_W-1:0]  outcode_t;

    typedef struct packed {
        logic ghost_en;
        logic fn_en;
    } cfg_t;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_OPEN = 2'd1,
        CAP_HELD = 2'd2
    } cap_state_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_PAIR = 2'd1,
        SC_WRAP = 2'd2
    } scan_state_e;

    function automatic logic [KF_COL_W-1:0] col_of(scan_t c);
        return c[KF_COL_W-1:0];
    endfunction

    function automatic logic [KF_ROW_W-1:0] row_of(scan_t c);
        return c[KF_CODE_W-1:KF_COL_W];
    endfunction

    // upper half of the doubled map: top bit carries the offset
    function automatic outcode_t lift(scan_t c, logic upper);
        return {upper, c};
    endfunction

endpackage

// File: rtl/kf_capture.sv
module kf_capture
    import kf_pkg::*;
#(
    parameter int    MAX_KEYS = 8,
    parameter scan_t FN_CODE  = 7'd60,
    localparam int   CNT_W    = $clog2(MAX_KEYS + 1),
    localparam int   IDX_W    = $clog2(MAX_KEYS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             frm_start,
    input  logic                             key_valid,
    input  scan_t                            key_code,
    input  logic                             frm_end,
    input  cfg_t                             cfg_in,
    input  logic                             release_i,
    output logic [MAX_KEYS-1:0][KF_CODE_W-1:0] keys,
    output logic [CNT_W-1:0]                 key_cnt,
    output logic                             fn_seen,
    output cfg_t                             cfg_q,
    output logic                             launch
);

    cap_state_e state;
    logic       is_fn;
    logic       has_room;

    assign is_fn    = cfg_q.fn_en && (key_code == FN_CODE);
    assign has_room = key_cnt < CNT_W'(MAX_KEYS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CAP_IDLE;
            keys    <= '0;
            key_cnt <= '0;
            fn_seen <= 1'b0;
            cfg_q   <= '0;
            launch  <= 1'b0;
        end else begin
            launch <= 1'b0;
            case (state)
                CAP_IDLE: begin
                    if (frm_start) begin
                        state   <= CAP_OPEN;
                        keys    <= '0;
                        key_cnt <= '0;
                        fn_seen <= 1'b0;
                        cfg_q   <= cfg_in;
                    end
                end
                CAP_OPEN: begin
                    if (key_valid) begin
                        if (is_fn) begin
                            fn_seen <= 1'b1;
                        end else if (has_room) begin
                            keys[key_cnt[IDX_W-1:0]] <= key_code;
                            key_cnt <= key_cnt + 1'b1;
                        end
                    end
                    if (frm_end) begin
                        state  <= CAP_HELD;
                        launch <= 1'b1;
                    end
                end
                CAP_HELD: begin
                    if (release_i) state <= CAP_IDLE;
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        key_cnt <= CNT_W'(MAX_KEYS));

    assert_held_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_HELD && !release_i) |=> ($stable(key_cnt) && $stable(keys) && $stable(fn_seen)));

endmodule

// File: rtl/kf_pair_scan.sv
module kf_pair_scan
    import kf_pkg::*;
#(
    parameter int  MAX_KEYS = 8,
    localparam int CNT_W    = $clog2(MAX_KEYS + 1),
    localparam int IDX_W    = $clog2(MAX_KEYS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               launch,
    input  logic [MAX_KEYS-1:0][KF_CODE_W-1:0] keys,
    input  logic [CNT_W-1:0]                   key_cnt,
    output logic [MAX_KEYS-1:0]                row_hit,
    output logic [MAX_KEYS-1:0]                col_hit,
    output logic                               scan_done
);

    scan_state_e       state;
    logic [CNT_W-1:0]  idx_i;
    logic [CNT_W-1:0]  idx_j;
    scan_t             key_a;
    scan_t             key_b;
    logic              same_row;
    logic              same_col;
    logic              last_j;
    logic              last_pair;
    logic [MAX_KEYS-1:0] row_set;
    logic [MAX_KEYS-1:0] col_set;

    assign key_a     = keys[idx_i[IDX_W-1:0]];
    assign key_b     = keys[idx_j[IDX_W-1:0]];
    assign same_row  = row_of(key_a) == row_of(key_b);
    assign same_col  = col_of(key_a) == col_of(key_b);
    assign last_j    = idx_j == (key_cnt - CNT_W'(1));
    assign last_pair = last_j && (idx_i == (key_cnt - CNT_W'(2)));

    for (genvar s = 0; s < MAX_KEYS; s++) begin : g_slot
        logic in_pair;
        assign in_pair    = (idx_i == CNT_W'(s)) || (idx_j == CNT_W'(s));
        assign row_set[s] = same_row && in_pair;
        assign col_set[s] = same_col && in_pair;
    end

    assign scan_done = (state == SC_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SC_IDLE;
            idx_i   <= '0;
            idx_j   <= '0;
            row_hit <= '0;
            col_hit <= '0;
        end else begin
            case (state)
                SC_IDLE: begin
                    if (launch) begin
                        idx_i   <= '0;
                        idx_j   <= CNT_W'(1);
                        row_hit <= '0;
                        col_hit <= '0;
                        state   <= (key_cnt >= CNT_W'(2)) ? SC_PAIR : SC_WRAP;
                    end
                end
                SC_PAIR: begin
                    row_hit <= row_hit | row_set;
                    col_hit <= col_hit | col_set;
                    if (last_pair) begin
                        state <= SC_WRAP;
                    end else if (last_j) begin
                        idx_i <= idx_i + 1'b1;
                        idx_j <= idx_i + CNT_W'(2);
                    end else begin
                        idx_j <= idx_j + 1'b1;
                    end
                end
                SC_WRAP: state <= SC_IDLE;
                default: state <= SC_IDLE;
            endcase
        end
    end

    assert_pair_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SC_PAIR) |-> ((idx_i < idx_j) && (idx_j < key_cnt)));

endmodule

// File: rtl/kf_report.sv
module kf_report
    import kf_pkg::*;
#(
    parameter int  MAX_KEYS = 8,
    localparam int CNT_W    = $clog2(MAX_KEYS + 1)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               scan_done,
    input  logic [MAX_KEYS-1:0][KF_CODE_W-1:0] keys,
    input  logic [CNT_W-1:0]                   key_cnt,
    input  logic                               fn_seen,
    input  logic                               ghost_en,
    input  logic [MAX_KEYS-1:0]                row_hit,
    input  logic [MAX_KEYS-1:0]                col_hit,
    output logic                               done,
    output logic                               discard,
    output logic [CNT_W-1:0]                   out_count,
    output logic [MAX_KEYS-1:0][KF_OUT_W-1:0]  out_codes
);

    logic                              ghost;
    logic [MAX_KEYS-1:0][KF_OUT_W-1:0] nxt_codes;

    assign ghost = ghost_en && (key_cnt >= CNT_W'(3)) && (|(row_hit & col_hit));

    for (genvar s = 0; s < MAX_KEYS; s++) begin : g_out
        assign nxt_codes[s] = (CNT_W'(s) < key_cnt) ? lift(keys[s], fn_seen) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            discard   <= 1'b0;
            out_count <= '0;
            out_codes <= '0;
        end else begin
            done <= scan_done;
            if (scan_done) begin
                discard   <= ghost;
                out_count <= key_cnt;
                out_codes <= nxt_codes;
            end
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_discard_min_keys_R5: assert property (@(posedge clk) disable iff (rst)
        discard |-> (out_count >= CNT_W'(3)));

endmodule

// File: rtl/keyscan_filter.sv
module keyscan_filter
    import kf_pkg::*;
#(
    parameter int    MAX_KEYS = 8,
    parameter scan_t FN_CODE  = 7'd60
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ghost_en,
    input  logic                              fn_layer_en,
    input  logic                              frm_start,
    input  logic                              key_valid,
    input  logic [KF_CODE_W-1:0]              key_code,
    input  logic                              frm_end,
    output logic                              done,
    output logic                              discard,
    output logic [$clog2(MAX_KEYS+1)-1:0]     out_count,
    output logic [MAX_KEYS*KF_OUT_W-1:0]      out_codes
);

    localparam int CNT_W = $clog2(MAX_KEYS + 1);

    logic [MAX_KEYS-1:0][KF_CODE_W-1:0] keys;
    logic [CNT_W-1:0]                   key_cnt;
    logic                               fn_seen;
    cfg_t                               cfg_in;
    cfg_t                               cfg_q;
    logic                               launch;
    logic [MAX_KEYS-1:0]                row_hit;
    logic [MAX_KEYS-1:0]                col_hit;
    logic                               scan_done;
    logic [MAX_KEYS-1:0][KF_OUT_W-1:0]  codes_arr;

    assign cfg_in.ghost_en = ghost_en;
    assign cfg_in.fn_en    = fn_layer_en;
    assign out_codes       = codes_arr;

    kf_capture #(.MAX_KEYS(MAX_KEYS), .FN_CODE(FN_CODE)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .key_valid (key_valid),
        .key_code  (key_code),
        .frm_end   (frm_end),
        .cfg_in    (cfg_in),
        .release_i (scan_done),
        .keys      (keys),
        .key_cnt   (key_cnt),
        .fn_seen   (fn_seen),
        .cfg_q     (cfg_q),
        .launch    (launch)
    );

    kf_pair_scan #(.MAX_KEYS(MAX_KEYS)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .keys      (keys),
        .key_cnt   (key_cnt),
        .row_hit   (row_hit),
        .col_hit   (col_hit),
        .scan_done (scan_done)
    );

    kf_report #(.MAX_KEYS(MAX_KEYS)) u_report (
        .clk       (clk),
        .rst       (rst),
        .scan_done (scan_done),
        .keys      (keys),
        .key_cnt   (key_cnt),
        .fn_seen   (fn_seen),
        .ghost_en  (cfg_q.ghost_en),
        .row_hit   (row_hit),
        .col_hit   (col_hit),
        .done      (done),
        .discard   (discard),
        .out_count (out_count),
        .out_codes (codes_arr)
    );

endmodule

// File: tb/keyscan_filter_bench.sv
module keyscan_filter_bench;

    localparam int MAXK = 8;
    localparam int FN   = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ghost_en = 1'b0;
    logic        fn_layer_en = 1'b0;
    logic        frm_start = 1'b0;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic        frm_end = 1'b0;
    logic        done;
    logic        discard;
    logic [3:0]  out_count;
    logic [63:0] out_codes;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int stim [0:15];
    int stim_n;
    int kept [0:7];
    int kept_n;
    bit exp_disc;
    int exp_codes [0:7];

    keyscan_filter u_keyscan_filter (
        .clk(clk), .rst(rst), .ghost_en(ghost_en), .fn_layer_en(fn_layer_en),
        .frm_start(frm_start), .key_valid(key_valid), .key_code(key_code),
        .frm_end(frm_end), .done(done), .discard(discard),
        .out_count(out_count), .out_codes(out_codes)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rc(input int row, input int col);
        return (row << 3) | col;  // R3 packing
    endfunction

    task automatic model(input bit ge, input bit fe);
        bit fn = 0;
        kept_n = 0;
        for (int i = 0; i < stim_n; i++) begin
            if (fe && stim[i] == FN) fn = 1;
            else if (kept_n < MAXK) begin kept[kept_n] = stim[i]; kept_n++; end
        end
        exp_disc = 0;
        if (ge && kept_n >= 3) begin
            for (int i = 0; i < kept_n; i++) begin
                bit rh = 0;
                bit ch = 0;
                for (int j = 0; j < kept_n; j++) begin
                    if (j != i && (kept[i] >> 3) == (kept[j] >> 3)) rh = 1;
                    if (j != i && (kept[i] & 7) == (kept[j] & 7)) ch = 1;
                end
                if (rh && ch) exp_disc = 1;
            end
        end
        for (int s = 0; s < MAXK; s++)
            exp_codes[s] = (s < kept_n) ? (kept[s] + (fn ? 128 : 0)) : 0;
    endtask

    task automatic run_frame(input bit ge, input bit fe, input bit flip, input bit stray, input string req);
        int dn = 0;
        int got_cnt = 0;
        bit got_disc = 0;
        logic [63:0] got_codes = '0;
        int bad = -1;
        @(negedge clk);
        ghost_en = ge; fn_layer_en = fe; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        for (int i = 0; i < stim_n; i++) begin
            key_valid = 1'b1;
            key_code  = 7'(stim[i]);
            if (flip && i == 0) begin ghost_en = !ge; fn_layer_en = !fe; end
            @(negedge clk);
        end
        key_valid = 1'b0;
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        if (stray) begin
            frm_start = 1'b1; key_valid = 1'b1; key_code = 7'd5; frm_end = 1'b1;
            @(negedge clk);
            frm_start = 1'b0; key_valid = 1'b0; frm_end = 1'b0;
        end
        repeat (60) begin
            @(negedge clk);
            if (done) begin
                dn++;
                got_cnt = int'(out_count); got_disc = discard; got_codes = out_codes;
            end
        end
        model(ge, fe);
        chk(dn == 1, {req, " R8"}, "done pulses", dn, 1);
        chk(got_cnt == kept_n, {req, " R2"}, "count", got_cnt, kept_n);
        chk(got_disc == exp_disc, req, "discard", int'(got_disc), int'(exp_disc));
        for (int s = MAXK - 1; s >= 0; s--)
            if (int'(got_codes[s*8 +: 8]) != exp_codes[s]) bad = s;
        if (bad < 0) chk(1, req, "codes", 0, 0);
        else chk(0, req, $sformatf("code slot %0d", bad), int'(got_codes[bad*8 +: 8]), exp_codes[bad]);
        if (stray) begin
            dn = 0;
            @(negedge clk);
            frm_end = 1'b1;
            @(negedge clk);
            frm_end = 1'b0;
            repeat (40) begin @(negedge clk); if (done) dn++; end
            chk(dn == 0, "R1", "done after lone end strobe", dn, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(done == 0 && discard == 0, "R9", "done/discard after reset", int'({done, discard}), 0);
        chk(out_count == 0 && out_codes == 0, "R9", "list after reset", int'(out_count), 0);

        // R1: key strobes while idle are ignored
        key_valid = 1'b1; key_code = 7'd9;
        @(negedge clk); key_valid = 1'b0;
        stim[0] = rc(2, 2); stim_n = 1;
        run_frame(1, 0, 0, 0, "R1");

        // R4 R3: L-shaped triple -> discard
        stim[0] = rc(1, 1); stim[1] = rc(1, 5); stim[2] = rc(6, 1); stim_n = 3;
        run_frame(1, 0, 0, 0, "R4");
        // R5: same with filter off
        run_frame(0, 0, 0, 0, "R5");
        // R5: two keys only
        stim_n = 2;
        run_frame(1, 0, 0, 0, "R5");
        // R4: three in one row, no column share -> kept
        stim[0] = rc(3, 0); stim[1] = rc(3, 4); stim[2] = rc(3, 7); stim_n = 3;
        run_frame(1, 0, 0, 0, "R4");
        // R6: function key removed, rest offset
        stim[0] = rc(0, 3); stim[1] = FN; stim[2] = rc(9, 6); stim_n = 3;
        run_frame(1, 1, 0, 0, "R6");
        // R7: function layer off -> ordinary key
        run_frame(1, 0, 0, 0, "R7");
        // R6 vs R7: function key closes the rectangle
        stim[0] = rc(7, 0); stim[1] = FN; stim[2] = rc(0, 4); stim_n = 3;
        run_frame(1, 1, 0, 0, "R6");
        run_frame(1, 0, 0, 0, "R7");
        // R2: overflow, then function key after the list is full
        for (int i = 0; i < 10; i++) stim[i] = rc(i, i & 7);
        stim[10] = FN; stim_n = 11;
        run_frame(0, 1, 0, 0, "R2");
        // R10: enables flipped mid-frame are ignored
        stim[0] = rc(1, 1); stim[1] = rc(1, 5); stim[2] = rc(6, 1); stim_n = 3;
        run_frame(1, 0, 1, 0, "R10");
        // R1: strobes during processing ignored
        run_frame(1, 0, 0, 1, "R1");
        // R8: empty frame still answers once
        stim_n = 0;
        run_frame(1, 1, 0, 0, "R8");

        // random frames, R4 R6 R7
        for (int f = 0; f < 200; f++) begin
            bit narrow = $urandom_range(0, 1) == 1;
            stim_n = $urandom_range(0, 10);
            for (int i = 0; i < stim_n; i++) begin
                int c;
                bit dup;
                do begin
                    if ($urandom_range(0, 9) == 0) c = FN;
                    else if (narrow) c = rc($urandom_range(0, 2), $urandom_range(0, 2));
                    else c = $urandom_range(0, 127);
                    dup = 0;
                    for (int k = 0; k < i; k++) if (stim[k] == c) dup = 1;
                end while (dup);
                stim[i] = c;
            end
            run_frame($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0, 0, "R4/R6 random");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule